// File: doc/BRIEF.md
# Modem Status and Loopback Unit

This block produces the modem status byte of a 16550-style serial port from the port's own modem control register. No external modem pins are sampled. When the loopback control bit is set, the four control outputs are folded back onto the four status line inputs. When it is clear, the status presents carrier detect and data-set-ready as permanently asserted, and clear-to-send and ring as deasserted.

Every write to the control register compares the old and new status lines. It latches a change flag in the low nibble of the status byte. Change flags stay set until software reads the status register. The ring flag latches only on a falling ring level. The OR of the flags is offered to the port's interrupt logic as a single pending signal.

Bit positions are the ones the neighbouring register decoder expects. Control register: bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loopback. Status register: bit 0 CTS change, bit 1 DSR change, bit 2 trailing ring edge, bit 3 DCD change, bit 4 CTS, bit 5 DSR, bit 6 RI, bit 7 DCD.

Top module: `msu_top`

## Requirements
- R1: A control write stores only data bits 4..0; `ctl_q[7:5]` always reads 0.
- R2: After reset `ctl_q` is 0x00, `stat_q` is 0xA0 and `delta_pend` is 0.
- R3: With `ctl_q[4]`=1 the status lines follow the control bits: RTS (bit 1) to CTS (bit 4), DTR (bit 0) to DSR (bit 5), OUT1 (bit 2) to RI (bit 6), OUT2 (bit 3) to DCD (bit 7).
- R4: With `ctl_q[4]`=0, `stat_q[7:4]` is 4'b1010 whatever the other control bits hold.
- R5: A control write that changes CTS, DSR or DCD sets status bit 0, 1 or 3 respectively; a write that changes none of them sets none of these bits.
- R6: Status bit 2 is set by a control write only when RI goes from 1 to 0, never when it goes from 0 to 1.
- R7: Change flags are sticky: later control writes replace bits 7..4 and keep any flag already set in bits 3..0.
- R8: During a cycle with `stat_rd`=1, `stat_q` shows the current value; from the next cycle bits 3..0 are 0 and bits 7..4 are unchanged.
- R9: When `stat_rd` and `ctl_wr` are both 1 in one cycle, the old flags are cleared and the flags raised by that write are kept.
- R10: A pulse on `stat_wr` changes neither `stat_q` nor `ctl_q`.
- R11: `delta_pend` is 1 exactly when any of `stat_q[3:0]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| stat_wr | input | 1 | Write strobe at the status address (ignored) |
| stat_rd | input | 1 | Status register read strobe |
| ctl_q | output | 8 | Control register contents |
| stat_q | output | 8 | Status register contents |
| delta_pend | output | 1 | A change flag is set |

## Verification
A wrong flag register shows up on `stat_q[3:0]` and on `delta_pend` one cycle after the control write or read strobe that misupdated it. Because flags are sticky, an error then persists until the next status read. A wrong line mapping is visible on `stat_q[7:4]` in the cycle after the write. It also leaves a false or missing flag behind, so the walked vector sequence checks each transition twice: once after the write and once after the read clears it.

// File: rtl/msu_pkg.sv
// Shared widths and bit positions for the modem status unit.
// Assumes the 16550-style layout that the register decoder relies on.
package msu_pkg;
    localparam int REG_W    = 8;
    localparam int LINE_N   = 4;
    localparam int CTL_KEEP = 5;

    // Control register bit positions
    localparam int C_DTR  = 0;
    localparam int C_RTS  = 1;
    localparam int C_OUT1 = 2;
    localparam int C_OUT2 = 3;
    localparam int C_LOOP = 4;

    // Line vector (status bits 7..4 shifted down) positions
    localparam int L_CTS = 0;
    localparam int L_DSR = 1;
    localparam int L_RI  = 2;
    localparam int L_DCD = 3;

    // Line levels presented when loopback is off
    localparam logic [LINE_N-1:0] LINE_IDLE = 4'b1010;
endpackage

// File: rtl/msu_ctl_reg.sv
// Control register: stores the low KEEP bits of each write, upper bits zero.
// Assumes one write strobe per cycle; reset value is zero.
module msu_ctl_reg #(
    parameter int W    = 8,
    parameter int KEEP = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] KEEP_MASK = W'((1 << KEEP) - 1);

    // Value the register takes at the coming edge
    always_comb begin
        nxt = wr ? (wdata & KEEP_MASK) : q;
    end

    // Register update
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/msu_line_map.sv
// Maps a control register value to the four status line levels.
// Purely combinational; loopback folds the outputs back, otherwise fixed levels.
module msu_line_map
    import msu_pkg::*;
(
    input  logic [REG_W-1:0]  ctl,
    output logic [LINE_N-1:0] line
);
    // Select loopback fold or idle levels
    always_comb begin
        if (ctl[C_LOOP]) begin
            line        = '0;
            line[L_CTS] = ctl[C_RTS];
            line[L_DSR] = ctl[C_DTR];
            line[L_RI]  = ctl[C_OUT1];
            line[L_DCD] = ctl[C_OUT2];
        end else begin
            line = LINE_IDLE;
        end
    end
endmodule

// File: rtl/msu_delta_track.sv
// Sticky change flags, one per line. The flag at index EDGE_IDX latches on a
// falling level only; all others latch on any change. A read clears old flags
// while flags raised in the same cycle survive.
module msu_delta_track #(
    parameter int N        = 4,
    parameter int EDGE_IDX = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [N-1:0] line_old,
    input  logic [N-1:0] line_new,
    input  logic         rd_clr,
    output logic [N-1:0] flags
);
    logic [N-1:0] hit;

    // Per-line change detection
    for (genvar i = 0; i < N; i++) begin : g_det
        if (i == EDGE_IDX) begin : g_fall
            assign hit[i] = upd & line_old[i] & ~line_new[i];
        end else begin : g_any
            assign hit[i] = upd & (line_old[i] ^ line_new[i]);
        end
    end

    // Flag register: clear-on-read, then OR in new hits
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (rd_clr ? '0 : flags) | hit;
    end
endmodule

// File: rtl/msu_top.sv
// Modem status and loopback unit top. Builds the status byte from the control
// register: line levels in bits 7..4, sticky change flags in bits 3..0.
// Assumes strobes are single-cycle and come from a synchronous register decoder.
module msu_top
    import msu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [REG_W-1:0] ctl_wdata,
    input  logic             stat_wr,
    input  logic             stat_rd,
    output logic [REG_W-1:0] ctl_q,
    output logic [REG_W-1:0] stat_q,
    output logic             delta_pend
);
    logic [REG_W-1:0]  ctl_nxt;
    logic [LINE_N-1:0] line_cur;
    logic [LINE_N-1:0] line_nxt;
    logic [LINE_N-1:0] flags;
    logic              stat_wr_unused;

    assign stat_wr_unused = stat_wr;

    msu_ctl_reg #(.W(REG_W), .KEEP(CTL_KEEP)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
        .q(ctl_q), .nxt(ctl_nxt)
    );

    msu_line_map u_map_cur (.ctl(ctl_q),   .line(line_cur));
    msu_line_map u_map_nxt (.ctl(ctl_nxt), .line(line_nxt));

    msu_delta_track #(.N(LINE_N), .EDGE_IDX(L_RI)) u_delta (
        .clk(clk), .rst_n(rst_n), .upd(ctl_wr),
        .line_old(line_cur), .line_new(line_nxt),
        .rd_clr(stat_rd), .flags(flags)
    );

    // Assemble the status byte and the pending signal
    always_comb begin
        stat_q     = {line_cur, flags};
        delta_pend = |flags;
    end
endmodule

// File: rtl/msu_chk.sv
// Property checker for msu_top, attached by bind.
module msu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr,
    input logic       stat_wr,
    input logic       stat_rd,
    input logic [7:0] ctl_q,
    input logic [7:0] stat_q,
    input logic       delta_pend
);
    p_ctl_hi_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[7:5] == 3'b000);

    p_loop_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[4] |-> stat_q[7:4] == {ctl_q[3], ctl_q[2], ctl_q[0], ctl_q[1]});

    p_idle_lines_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[4] |-> stat_q[7:4] == 4'b1010);

    p_flag_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_pend) |-> $past(ctl_wr));

    p_teri_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[2]) |-> $fell(stat_q[6]));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> (stat_q[3:0] & $past(stat_q[3:0])) == $past(stat_q[3:0]));

    p_rd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !ctl_wr) |=> stat_q[3:0] == 4'b0000);

    p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr && !stat_rd) |=> $stable(stat_q) && $stable(ctl_q));

    p_pend_r11: assert property (@(posedge clk) disable iff (!rst_n)
        delta_pend == (stat_q[3:0] != 4'b0000));
endmodule

bind msu_top msu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .stat_wr(stat_wr),
    .stat_rd(stat_rd), .ctl_q(ctl_q), .stat_q(stat_q), .delta_pend(delta_pend)
);

// File: tb/msu_top_tb.sv
module msu_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;
    // {write data, expected ctl_q, expected stat_q after write}
    localparam logic [23:0] VEC [NVEC] = '{
        24'hE0_00_A0,   // R1: upper bits dropped, no change
        24'h10_10_0A,   // R3 R5: loopback, DSR/DCD fall
        24'h12_12_11,   // R3 R5: RTS -> CTS
        24'h14_14_41,   // R6: RI rises, no TERI; CTS falls
        24'h10_10_04,   // R6: RI falls -> TERI
        24'h19_19_AA,   // R3: DTR, OUT2
        24'hFF_1F_F1,   // R1 R6: all on
        24'h0F_0F_A5,   // R4: leave loopback
        24'h0F_0F_A0    // R5: no change, no flags
    };

    logic clk = 0, rst_n = 0, ctl_wr = 0, stat_wr = 0, stat_rd = 0;
    logic [7:0] ctl_wdata = 0;
    logic [7:0] ctl_q, stat_q;
    logic delta_pend;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msu_top u_dut (.clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .stat_wr(stat_wr), .stat_rd(stat_rd), .ctl_q(ctl_q), .stat_q(stat_q),
        .delta_pend(delta_pend));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        @(negedge clk); ctl_wr = 1; ctl_wdata = d;
        @(negedge clk); ctl_wr = 0;
    endtask

    task automatic rd_stat(output logic [7:0] seen);
        @(negedge clk); stat_rd = 1; seen = stat_q;
        @(negedge clk); stat_rd = 0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] seen;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R2 ctl", ctl_q, 8'h00);
        chk("R2 stat", stat_q, 8'hA0);
        chk("R2 pend", {7'd0, delta_pend}, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            wr_ctl(VEC[i][23:16]);
            chk("R1 ctl", ctl_q, VEC[i][15:8]);
            chk("R3-R6 stat", stat_q, VEC[i][7:0]);
            chk("R11 pend", {7'd0, delta_pend}, {7'd0, |VEC[i][3:0]});
            rd_stat(seen);
            chk("R8 seen", seen, VEC[i][7:0]);
            chk("R8 cleared", stat_q, VEC[i][7:0] & 8'hF0);
        end

        // R7 sticky across writes
        wr_ctl(8'h10);
        chk("R7 first", stat_q, 8'h0A);
        wr_ctl(8'h12);
        chk("R7 sticky", stat_q, 8'h1B);

        // R9 read and write in one cycle
        @(negedge clk); ctl_wr = 1; ctl_wdata = 8'h10; stat_rd = 1;
        @(negedge clk); ctl_wr = 0; stat_rd = 0;
        chk("R9 merge", stat_q, 8'h01);

        // R10 status write ignored
        @(negedge clk); stat_wr = 1;
        @(negedge clk); stat_wr = 0;
        chk("R10 stat", stat_q, 8'h01);
        chk("R10 ctl", ctl_q, 8'h10);
        chk("R11 pend", {7'd0, delta_pend}, 8'h01);

        // R2 reset clears flags and control
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        chk("R2 re-reset", stat_q, 8'hA0);
        chk("R2 re-ctl", ctl_q, 8'h00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule